// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-side controller of a byte-organised serial EEPROM that sits on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The controller detects START and STOP conditions and recognises its own device address. That address is a fixed 4-bit prefix followed by three strap inputs. The controller then runs one of two sequences. A write sequence loads a word address and passes data bytes to the array's page buffer. A read sequence streams bytes out of a synchronous memory port. The data line is driven only as an open-drain pull-down enable.

A master sets the array pointer in one of two ways. It can send a write command that carries a two-byte word address. It can also start with a dummy write that only loads the address, then issue a repeated START and a read command. The pointer is one counter. Every byte written or sent advances it, and it stays in place between transactions. A read with no address phase therefore resumes where the last transfer stopped.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. After reset or a STOP, the block ignores all traffic until a START: bytes clocked without a START get no acknowledge.
- R2: The address byte carries 4'b1010 in bits 7:4 and `strap_i[2:0]` in bits 3:1. Bit 0 is the direction (1 = read, 0 = write). The block acknowledges only when all seven upper bits match.
- R3: After a non-matching address byte, the block leaves SDA released until the next START or STOP. It issues no write strobe, and any bytes clocked in get no acknowledge.
- R4: In a write transaction, the block pulls SDA low for the whole ninth clock after the address byte, after each word-address byte and after each data byte.
- R5: The word address follows a write address as two bytes, high byte first. Only the low ADDR_W bits of the combined 16-bit value are used; the higher bits are ignored.
- R6: The block changes `sda_oe_o` only while the synchronised SCL is low.
- R7: Each data byte received in a write transaction gives one `wr_en_o` pulse. The pulse carries the current pointer on `wr_addr_o` and the byte on `wr_data_o`. The pointer then advances by one.
- R8: After a read address, the block sends the byte at the pointer MSB first, one bit per SCL period. It then releases SDA for the ninth clock, and the pointer advances by one.
- R9: If the master acknowledges a read byte, the next byte follows from the advanced pointer. If it does not acknowledge, the block releases SDA and drives nothing until a STOP or START.
- R10: The pointer wraps from 2^ADDR_W-1 to 0, on both writes and reads.
- R11: A repeated START anywhere restarts device-address reception. A dummy write of the word address followed by a repeated START and a read returns data from the loaded address.
- R12: The pointer keeps its value across a STOP, so a read that skips the address phase starts where the previous transaction left it.
- R13: During and right after reset, `sda_oe_o`, `wr_en_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Device-select straps, matched against address bits 3:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_en_o | output | 1 | One-cycle write strobe to the page buffer |
| wr_addr_o | output | ADDR_W | Array address of the write byte |
| wr_data_o | output | 8 | Write byte |
| rd_req_o | output | 1 | One-cycle read request to the synchronous array port |
| rd_addr_o | output | ADDR_W | Array address of the read request |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_req_o` |

## Verification
The bench builds the block with ADDR_W = 10, so the array has 1024 bytes and the upper six bits of the high word-address byte must be discarded. Random junk in those bits therefore tests the masking on every transaction. The small array puts the wrap from 1023 to 0 within reach of short bursts on both the write and the read path. The straps are tied to 3'b101, so one flipped strap bit and one flipped prefix bit each give a distinct mismatch case.

// File: rtl/i2c_eep_pkg.sv
// Shared types and constants for the two-wire EEPROM slave controller.
// Assumes: nothing beyond the standard; imported by the top module only.
package i2c_eep_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte
        ST_ACK,    // holding SDA low for the ninth clock
        ST_TX,     // shifting out a read byte
        ST_RACK,   // sampling the master's acknowledge
        ST_WAIT    // released, waiting for STOP or START
    } ctl_st_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_DEV,     // device address byte
        K_AHI,     // word address, high byte
        K_ALO,     // word address, low byte
        K_DATA     // write data byte
    } rx_kind_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_eep_sync.sv
// Bus line conditioner: synchronises SCL and SDA into the system clock
// domain through SYNC_STAGES flops, then flags SCL edges and START/STOP.
// Assumes: the system clock is several times faster than SCL; SYNC_STAGES >= 2.
module i2c_eep_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchroniser chains; the idle bus level (high) is the reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[SYNC_STAGES-1];
            sda_q <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_o      = scl_pipe[SYNC_STAGES-1];
        sda_o      = sda_pipe[SYNC_STAGES-1];
        scl_rise_o = scl_o & ~scl_q;
        scl_fall_o = ~scl_o & scl_q;
        start_o    = scl_o & scl_q & sda_q & ~sda_o;
        stop_o     = scl_o & scl_q & ~sda_q & sda_o;
    end

endmodule

// File: rtl/i2c_eep_rx_shift.sv
// Receive shifter: collects one byte MSB first on SCL rising edges and
// reports when eight bits are held.
// Assumes: the controller clears it before each byte.
module i2c_eep_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       sample_i,
    input  logic       bit_i,
    output logic [7:0] byte_o,
    output logic       full_o
);

    logic [3:0] cnt_q;

    // Shift in one bit per sample until the byte is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            byte_o <= '0;
        end else if (clear_i) begin
            cnt_q  <= '0;
        end else if (sample_i && !full_o) begin
            byte_o <= {byte_o[6:0], bit_i};
            cnt_q  <= cnt_q + 4'd1;
        end
    end

    // Byte-complete flag
    assign full_o = cnt_q[3];

endmodule

// File: rtl/i2c_eep_addr_ctr.sv
// Array pointer: loaded from the word address, advanced after each byte
// written or sent, wrapping at the top of the 2^ADDR_W array.
// Assumes: load and inc are never requested in the same cycle.
module i2c_eep_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Pointer register with natural modulo wrap
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= load_val_i;
        else if (inc_i)  addr_o <= addr_o + 1'b1;
    end

    // R10: one step per increment, wrapping to zero at the top
    a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i) |=> (addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/eeprom_i2c_slave.sv
// Two-wire EEPROM slave controller top. It matches the device address
// against a fixed prefix and straps, loads a two-byte word address and then
// streams write bytes to the page buffer or read bytes from the array port.
// Assumes: rd_data_i is valid one cycle after rd_req_o; 9 <= ADDR_W <= 16;
// SCL high and low phases each last several system clocks.
module eeprom_i2c_slave
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    localparam int HI_W = ADDR_W - 8;

    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0]        rx_byte;
    logic              rx_full, rx_clear;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_load, ptr_inc;

    ctl_st_t           st_q;
    rx_kind_t          kind_q;
    logic              rd_mode_q;
    logic [HI_W-1:0]   hi_q;
    logic [7:0]        tx_sh_q;
    logic [2:0]        tx_cnt_q;
    logic [7:0]        tx_buf_q;
    logic              rd_pend_q;
    logic              mack_q;
    logic              ev_ok;
    logic              byte_done;
    logic              dev_hit;

    i2c_eep_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_eep_rx_shift u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (rx_clear),
        .sample_i (scl_rise),
        .bit_i    (sda_s),
        .byte_o   (rx_byte),
        .full_o   (rx_full)
    );

    i2c_eep_addr_ctr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i ({hi_q, rx_byte}),
        .inc_i      (ptr_inc),
        .addr_o     (ptr)
    );

    // Strobes for the shifter and the pointer, suppressed on bus conditions
    always_comb begin
        ev_ok     = !bus_start && !bus_stop;
        byte_done = ev_ok && (st_q == ST_RX) && scl_fall && rx_full;
        dev_hit   = (rx_byte[7:1] == {DEV_PREFIX, strap_i});
        rx_clear  = bus_start || (ev_ok && (st_q == ST_ACK) && scl_fall && !rd_mode_q);
        ptr_load  = byte_done && (kind_q == K_ALO);
        ptr_inc   = (byte_done && (kind_q == K_DATA))
                 || (ev_ok && scl_fall && (st_q == ST_ACK) && rd_mode_q)
                 || (ev_ok && scl_fall && (st_q == ST_RACK) && mack_q);
    end

    // Main sequencer: bus conditions first, then per-state SCL-edge handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            kind_q    <= K_DEV;
            rd_mode_q <= 1'b0;
            hi_q      <= '0;
            tx_sh_q   <= '0;
            tx_cnt_q  <= '0;
            mack_q    <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            rd_req_o  <= 1'b0;
            rd_addr_o <= '0;
        end else begin
            wr_en_o  <= 1'b0;
            rd_req_o <= 1'b0;
            if (bus_start) begin
                st_q     <= ST_RX;
                kind_q   <= K_DEV;
                sda_oe_o <= 1'b0;
            end else if (bus_stop) begin
                st_q     <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_RX: if (scl_fall && rx_full) begin
                        st_q     <= ST_ACK;
                        sda_oe_o <= 1'b1;
                        unique case (kind_q)
                            K_DEV: begin
                                if (dev_hit) begin
                                    rd_mode_q <= rx_byte[0];
                                    kind_q    <= K_AHI;
                                    rd_req_o  <= rx_byte[0];
                                    rd_addr_o <= ptr;
                                end else begin
                                    st_q     <= ST_WAIT;
                                    sda_oe_o <= 1'b0;
                                end
                            end
                            K_AHI: begin
                                hi_q   <= rx_byte[HI_W-1:0];
                                kind_q <= K_ALO;
                            end
                            K_ALO: kind_q <= K_DATA;
                            K_DATA: begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr;
                                wr_data_o <= rx_byte;
                            end
                            default: ;
                        endcase
                    end
                    ST_ACK: if (scl_fall) begin
                        if (rd_mode_q) begin
                            st_q     <= ST_TX;
                            tx_sh_q  <= tx_buf_q;
                            tx_cnt_q <= '0;
                            sda_oe_o <= ~tx_buf_q[7];
                        end else begin
                            st_q     <= ST_RX;
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (tx_cnt_q == 3'd7) begin
                            st_q     <= ST_RACK;
                            sda_oe_o <= 1'b0;
                        end else begin
                            tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                            sda_oe_o <= ~tx_sh_q[6];
                            tx_cnt_q <= tx_cnt_q + 3'd1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                            if (!sda_s) begin
                                rd_req_o  <= 1'b1;
                                rd_addr_o <= ptr;
                            end
                        end
                        if (scl_fall) begin
                            if (mack_q) begin
                                st_q     <= ST_TX;
                                tx_sh_q  <= tx_buf_q;
                                tx_cnt_q <= '0;
                                sda_oe_o <= ~tx_buf_q[7];
                            end else begin
                                st_q <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read-data capture, one cycle after the array sees the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            tx_buf_q  <= '0;
        end else begin
            rd_pend_q <= rd_req_o;
            if (rd_pend_q) tx_buf_q <= rd_data_i;
        end
    end

    // R6: SDA drive may rise only while SCL is low
    a_r6_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);
    // R6: SDA drive may fall only while SCL is low
    a_r6_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_s);
    // R7: a write strobe coincides with the start of the data acknowledge
    a_r7_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sda_oe_o);
    // R3: nothing is driven while waiting for the end of the transaction
    a_r3_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> !sda_oe_o);
    // R9: the array port never sees a write and a read in the same cycle
    a_r9_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_req_o));

endmodule

// File: tb/eeprom_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb_top;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int Q     = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          sda_line;
    logic          wr_en, rd_req;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;

    logic [7:0]    mem  [0:DEPTH-1];
    logic [7:0]    refm [0:DEPTH-1];

    int n_chk = 0;
    int n_err = 0;
    int n_wr  = 0;
    int exp_wa = 0;
    int exp_wd = 0;
    int cur    = 0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_slave #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .strap_i   (STRAP),
        .sda_oe_o  (sda_oe),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_req_o  (rd_req),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    // Synchronous array model
    always @(posedge clk) begin
        if (wr_en)  mem[wr_addr] <= wr_data;
        if (rd_req) rd_data <= mem[rd_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R7 write strobe monitor and R6 drive-timing monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            n_wr++;
            chk(wr_addr == exp_wa[AW-1:0], "R7 wr_addr", wr_addr, exp_wa);
            chk(wr_data == exp_wd[7:0], "R7 wr_data", wr_data, exp_wd);
        end
        if (rst_n && sda_oe != prev_oe)
            chk(!scl_m, "R6 sda_oe change with SCL high", scl_m, 0);
        prev_oe = sda_oe;
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    function automatic logic [7:0] hi_byte(input int a, input int junk);
        return 8'(((junk << (AW - 8)) | (a >> 8)) & 8'hFF);
    endfunction

    // Address phase: START, write address, two word-address bytes (R4, R5)
    task automatic addr_phase(input int a, input int junk);
        logic ack;
        bus_start();
        send_byte(DEVW, ack);
        chk(ack, "R4 ack on write address", ack, 1);
        send_byte(hi_byte(a, junk), ack);
        chk(ack, "R5 ack on high word-address byte", ack, 1);
        send_byte(8'(a & 8'hFF), ack);
        chk(ack, "R5 ack on low word-address byte", ack, 1);
    endtask

    // Write burst of n random bytes at a (R7, R10)
    task automatic txn_write(input int a, input int n, input int junk);
        logic ack;
        logic [7:0] d;
        addr_phase(a, junk);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            exp_wa = (a + k) % DEPTH;
            exp_wd = d;
            send_byte(d, ack);
            chk(ack, "R4 ack on data byte", ack, 1);
            refm[(a + k) % DEPTH] = d;
        end
        bus_stop();
        cur = (a + n) % DEPTH;
    endtask

    // Read burst of n bytes; with set_addr a dummy write plus repeated START (R11)
    task automatic txn_read(input bit set_addr, input int a, input int n, input int junk,
                            input bit extra_after_nack);
        logic ack;
        logic [7:0] d;
        int base;
        base = set_addr ? a : cur;
        if (set_addr) addr_phase(a, junk);
        bus_start();
        send_byte(DEVR, ack);
        chk(ack, "R8 ack on read address", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(d == refm[(base + k) % DEPTH],
                set_addr ? "R11 R8 R9 R10 read data" : "R12 R8 read data",
                d, refm[(base + k) % DEPTH]);
        end
        if (extra_after_nack) begin
            recv_byte(1'b0, d);
            chk(d == 8'hFF, "R9 line released after NACK", d, 8'hFF);
        end
        bus_stop();
        cur = (base + n) % DEPTH;
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        int wr_before;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  = 8'((i * 37 + 5) & 8'hFF);
            refm[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk(!sda_oe && !wr_en && !rd_req, "R13 outputs low in reset",
            {sda_oe, wr_en, rd_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sda_oe && !wr_en && !rd_req, "R13 outputs low after reset",
            {sda_oe, wr_en, rd_req}, 0);

        // R1: bytes without START are ignored
        send_byte(DEVW, ack);
        chk(!ack, "R1 no ack without START", ack, 0);
        bus_stop();

        // R10: write across the top of the array, then read across it
        txn_write(DEPTH - 2, 4, 0);
        txn_read(1'b1, DEPTH - 1, 3, 8'h3F, 1'b0);

        // R12: current-address read after a write
        txn_write(100, 2, 5);
        txn_read(1'b0, 0, 2, 0, 1'b0);

        // R2 R3: strap mismatch, no ack, no strobe
        wr_before = n_wr;
        bus_start();
        send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, ack);
        chk(!ack, "R2 no ack on strap mismatch", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R3 no ack after mismatch", ack, 0);
        send_byte(8'h55, ack);
        chk(!ack, "R3 no ack on data after mismatch", ack, 0);
        bus_stop();
        chk(n_wr == wr_before, "R3 no write strobe after mismatch", n_wr, wr_before);

        // R2 R3: prefix mismatch on a read, line stays released
        bus_start();
        send_byte({4'b1011, STRAP, 1'b1}, ack);
        chk(!ack, "R2 no ack on prefix mismatch", ack, 0);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R3 released after prefix mismatch", d, 8'hFF);
        bus_stop();

        // R9: NACK then extra clocks, then current read resumes
        txn_read(1'b1, 500, 3, 8'h15, 1'b1);
        txn_read(1'b0, 0, 1, 0, 1'b0);

        // Random traffic with junk upper word-address bits (R5, R7, R8)
        for (int it = 0; it < 10; it++) begin
            int a, n, junk;
            a    = $urandom % DEPTH;
            n    = 1 + ($urandom % 4);
            junk = $urandom % 64;
            txn_write(a, n, junk);
            txn_read(1'b1, a, n, $urandom % 64, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule